// File: doc/BRIEF.md
# Audio Serial Frame-Sync Generator

This block produces the bit clock and frame sync for an audio serial port. It divides its input clock down to a bit clock. It then counts bit clocks to build frames whose length and pulse width are set in bit-clock units. Two framing presets derive both values from a word length and a channel count. One is a half-frame pulse for two-channel word framing. The other is a single-bit pulse for packed multi-channel framing. A custom mode takes the two values directly.

As master, the block drives identical bit clock and frame sync copies to the transmit and receive pins and raises their drive enables. As slave, it releases the pins and forwards an externally supplied bit clock and frame sync to its core-side outputs through one register stage. Configuration is written through a four-entry register port. Every setting is staged and only applied at a frame boundary, so a frame is never cut short or reshaped while it runs.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset, both drive enables are low, all four pin outputs and both core-side outputs are 0, and no frame runs until the control register is written.
- R2: The divider field (address 1) holds the bit-clock ratio minus one. For a field value D of 2 or more, each bit lasts N = D+1 input cycles. The bit clock is high for the first floor(N/2) cycles of each bit and low for the rest.
- R3: A divider field of 0 or 1 makes the bit clock equal to the input clock, so one bit passes per input cycle.
- R4: In custom framing (control bits [5:4] = 0), a frame lasts period field (address 2) plus one bits. The frame sync is active for the first width field (address 3) plus one bits. A width field at or above the period field keeps the frame sync active for the whole frame.
- R5: With control bits [5:4] = 1 and word length W = control bits [10:6] plus one, a frame lasts 2W bits and the frame sync is active for W bits.
- R6: With control bits [5:4] = 2, W as in R5 and channel count C = control bits [12:11] plus one, a frame lasts W*C bits and the frame sync is active for one bit.
- R7: While generating (control bit 0 enable = 1 and control bit 1 master = 1), both drive enables are high, and the transmit and receive copies of each signal are identical.
- R8: With enable = 1 and master = 0, both drive enables stay low. The core-side bit clock and frame sync follow the external inputs one input cycle later, each XORed with its polarity bit.
- R9: Writes to any register take effect at the next frame boundary. Clearing enable lets the running frame finish before generation stops, and writes made without enable start nothing.
- R10: The first input cycle after enable shows the frame sync active and the bit clock in its high half. While not generating, each pin output rests at its inactive level, which equals its polarity bit, and the core-side outputs are 0.
- R11: Control bit 2 inverts the bit clock on the pins and control bit 3 inverts the frame sync on the pins. The core-side outputs are always active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, source of the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 divider, 2 period, 3 width |
| cfg_wdata | input | DATA_W | Register write data |
| ext_bclk | input | 1 | Bit clock from outside (slave mode) |
| ext_fs | input | 1 | Frame sync from outside (slave mode) |
| tx_bclk | output | 1 | Transmit bit clock pin value |
| rx_bclk | output | 1 | Receive bit clock pin value |
| tx_fs | output | 1 | Transmit frame sync pin value |
| rx_fs | output | 1 | Receive frame sync pin value |
| clk_oe | output | 1 | Drive enable for both bit clock pins |
| fs_oe | output | 1 | Drive enable for both frame sync pins |
| core_bclk | output | 1 | Active-high bit clock toward the data path |
| core_fs | output | 1 | Active-high frame sync toward the data path |

## Verification
The generated waveform is compared every input cycle against frames the bench builds from the formulas. Divider settings of 0, 1, 2, 3 and 4 separate the pass-through case from even and odd ratios, where the high-half rounding matters. Custom, word-pair and packed framing are each run with a width below the period, and one custom case has a width above it, so the three ways of deriving period and width are told apart. A mid-frame rewrite of period, width and divider shows whether new values leak into the running frame. A disable in the middle of a frame shows whether the last frame is cut short. Inverted polarities and slave pass-through separate the pin levels from the core-side levels.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;

  // Framing presets selected by control bits [5:4]
  typedef enum logic [1:0] {
    FR_CUSTOM = 2'd0,
    FR_WPAIR  = 2'd1,
    FR_PACKED = 2'd2,
    FR_SPARE  = 2'd3
  } frame_mode_e;

  // Control word; the first field is the most significant bit
  typedef struct packed {
    logic [1:0]  chan_m1;   // [12:11]
    logic [4:0]  wlen_m1;   // [10:6]
    frame_mode_e mode;      // [5:4]
    logic        fs_inv;    // [3]
    logic        bclk_inv;  // [2]
    logic        master;    // [1]
    logic        enable;    // [0]
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int NUM_REGS = 4;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int NUM_DIR  = 2;   // transmit and receive copies

  localparam int A_CTRL = 0;
  localparam int A_DIV  = 1;
  localparam int A_PER  = 2;
  localparam int A_WID  = 3;

endpackage

// File: rtl/fsg_regs.sv
`timescale 1ns/1ps
module fsg_regs
  import fsg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output ctrl_t             stg_ctrl,
  output logic [DIV_W-1:0]  stg_div,
  output logic [CNT_W-1:0]  stg_per,
  output logic [CNT_W-1:0]  stg_wid
);

  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign hit[g] = cfg_we && (cfg_addr == REG_AW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_ctrl <= '0;
      stg_div  <= '0;
      stg_per  <= '0;
      stg_wid  <= '0;
    end else begin
      if (hit[A_CTRL]) stg_ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      if (hit[A_DIV])  stg_div  <= cfg_wdata[DIV_W-1:0];
      if (hit[A_PER])  stg_per  <= cfg_wdata[CNT_W-1:0];
      if (hit[A_WID])  stg_wid  <= cfg_wdata[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/fsg_preset.sv
`timescale 1ns/1ps
module fsg_preset
  import fsg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] raw_per,
  input  logic [CNT_W-1:0] raw_wid,
  output logic [CNT_W-1:0] eff_per,
  output logic [CNT_W-1:0] eff_wid
);

  logic [CNT_W-1:0] wlen;
  logic [CNT_W-1:0] chans;
  logic [CNT_W-1:0] packed_bits;

  assign wlen        = CNT_W'(ctrl.wlen_m1) + CNT_W'(1);
  assign chans       = CNT_W'(ctrl.chan_m1) + CNT_W'(1);
  assign packed_bits = wlen * chans;

  always_comb begin
    unique case (ctrl.mode)
      FR_WPAIR: begin
        eff_per = CNT_W'({ctrl.wlen_m1, 1'b1});  // 2W - 1
        eff_wid = CNT_W'(ctrl.wlen_m1);          // W - 1
      end
      FR_PACKED: begin
        eff_per = packed_bits - CNT_W'(1);       // W*C - 1
        eff_wid = '0;                            // one bit
      end
      default: begin
        eff_per = raw_per;
        eff_wid = raw_wid;
      end
    endcase
  end

endmodule

// File: rtl/fsg_core.sv
`timescale 1ns/1ps
module fsg_core #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stg_run,
  input  logic [DIV_W-1:0] stg_div,
  input  logic [CNT_W-1:0] stg_per,
  input  logic [CNT_W-1:0] stg_wid,
  input  logic             stg_binv,
  input  logic             stg_finv,
  output logic             running,
  output logic             bclk_q,
  output logic             fs_q,
  output logic             bypass,
  output logic             act_binv,
  output logic             act_finv
);

  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] divcnt;
  logic [DIV_W-1:0] divcnt_inc;
  logic [CNT_W-1:0] act_per;
  logic [CNT_W-1:0] act_wid;
  logic [CNT_W-1:0] bitcnt;
  logic [CNT_W-1:0] bitcnt_inc;
  logic [DIV_W:0]   high_len;
  logic             last_cyc;
  logic             frame_end;
  logic             start;

  assign bypass     = act_div <= DIV_W'(1);
  assign high_len   = ({1'b0, act_div} + (DIV_W+1)'(1)) >> 1;
  assign divcnt_inc = divcnt + DIV_W'(1);
  assign bitcnt_inc = bitcnt + CNT_W'(1);
  assign last_cyc   = bypass || (divcnt == act_div);
  assign frame_end  = running && last_cyc && (bitcnt == act_per);
  assign start      = !running && stg_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      bclk_q   <= 1'b0;
      fs_q     <= 1'b0;
      divcnt   <= '0;
      bitcnt   <= '0;
      act_div  <= '0;
      act_per  <= '0;
      act_wid  <= '0;
      act_binv <= 1'b0;
      act_finv <= 1'b0;
    end else if (start || (frame_end && stg_run)) begin
      // open a frame with the staged settings
      running  <= 1'b1;
      bclk_q   <= 1'b1;
      fs_q     <= 1'b1;
      divcnt   <= '0;
      bitcnt   <= '0;
      act_div  <= stg_div;
      act_per  <= stg_per;
      act_wid  <= stg_wid;
      act_binv <= stg_binv;
      act_finv <= stg_finv;
    end else if (frame_end) begin
      running <= 1'b0;
      bclk_q  <= 1'b0;
      fs_q    <= 1'b0;
      divcnt  <= '0;
      bitcnt  <= '0;
    end else if (running) begin
      if (last_cyc) begin
        divcnt <= '0;
        bitcnt <= bitcnt_inc;
        bclk_q <= 1'b1;
        fs_q   <= bitcnt_inc <= act_wid;
      end else begin
        divcnt <= divcnt_inc;
        bclk_q <= {1'b0, divcnt_inc} < high_len;
      end
    end
  end

  p_bit_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    running |-> (bitcnt <= act_per));

  p_div_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (running && !bypass) |-> (divcnt <= act_div));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (running && !frame_end) |=> $stable({act_div, act_per, act_wid, act_binv, act_finv}));

  p_stop_on_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(frame_end));

  p_frame_opens_r10: assert property (@(posedge clk) disable iff (rst)
    (running && bitcnt == '0 && divcnt == '0) |-> (fs_q && bclk_q));

endmodule

// File: rtl/fsg_pins.sv
`timescale 1ns/1ps
module fsg_pins
  import fsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic bclk_q,
  input  logic fs_q,
  input  logic bypass,
  input  logic act_binv,
  input  logic act_finv,
  input  logic stg_en,
  input  logic stg_master,
  input  logic stg_binv,
  input  logic stg_finv,
  input  logic ext_bclk,
  input  logic ext_fs,
  output logic [NUM_DIR-1:0] pad_bclk,
  output logic [NUM_DIR-1:0] pad_fs,
  output logic [NUM_DIR-1:0] pad_oe,
  output logic core_bclk,
  output logic core_fs
);

  logic sl_bclk_q;
  logic sl_fs_q;
  logic slave_sel;
  logic gen_bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      sl_bclk_q <= 1'b0;
      sl_fs_q   <= 1'b0;
    end else begin
      sl_bclk_q <= ext_bclk ^ stg_binv;
      sl_fs_q   <= ext_fs ^ stg_finv;
    end
  end

  assign slave_sel = stg_en && !stg_master && !running;
  assign gen_bclk  = bypass ? clk : bclk_q;

  assign core_bclk = running ? gen_bclk : (slave_sel ? sl_bclk_q : 1'b0);
  assign core_fs   = running ? fs_q     : (slave_sel ? sl_fs_q   : 1'b0);

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    assign pad_bclk[d] = running ? (gen_bclk ^ act_binv) : stg_binv;
    assign pad_fs[d]   = running ? (fs_q ^ act_finv)     : stg_finv;
    assign pad_oe[d]   = running;
  end

  p_slave_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (slave_sel && $past(slave_sel)) |-> (core_fs == $past(ext_fs ^ stg_finv)));

endmodule

// File: rtl/frame_sync_gen.sv
`timescale 1ns/1ps
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ext_bclk,
  input  logic              ext_fs,
  output logic              tx_bclk,
  output logic              rx_bclk,
  output logic              tx_fs,
  output logic              rx_fs,
  output logic              clk_oe,
  output logic              fs_oe,
  output logic              core_bclk,
  output logic              core_fs
);

  ctrl_t              stg_ctrl;
  logic [DIV_W-1:0]   stg_div;
  logic [CNT_W-1:0]   raw_per;
  logic [CNT_W-1:0]   raw_wid;
  logic [CNT_W-1:0]   eff_per;
  logic [CNT_W-1:0]   eff_wid;
  logic               running;
  logic               bclk_q;
  logic               fs_q;
  logic               bypass;
  logic               act_binv;
  logic               act_finv;
  logic [NUM_DIR-1:0] pad_bclk;
  logic [NUM_DIR-1:0] pad_fs;
  logic [NUM_DIR-1:0] pad_oe;

  fsg_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .stg_ctrl(stg_ctrl), .stg_div(stg_div),
    .stg_per(raw_per), .stg_wid(raw_wid)
  );

  fsg_preset #(.CNT_W(CNT_W)) u_preset (
    .ctrl(stg_ctrl), .raw_per(raw_per), .raw_wid(raw_wid),
    .eff_per(eff_per), .eff_wid(eff_wid)
  );

  fsg_core #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .stg_run(stg_ctrl.enable && stg_ctrl.master),
    .stg_div(stg_div), .stg_per(eff_per), .stg_wid(eff_wid),
    .stg_binv(stg_ctrl.bclk_inv), .stg_finv(stg_ctrl.fs_inv),
    .running(running), .bclk_q(bclk_q), .fs_q(fs_q), .bypass(bypass),
    .act_binv(act_binv), .act_finv(act_finv)
  );

  fsg_pins u_pins (
    .clk(clk), .rst(rst), .running(running), .bclk_q(bclk_q), .fs_q(fs_q),
    .bypass(bypass), .act_binv(act_binv), .act_finv(act_finv),
    .stg_en(stg_ctrl.enable), .stg_master(stg_ctrl.master),
    .stg_binv(stg_ctrl.bclk_inv), .stg_finv(stg_ctrl.fs_inv),
    .ext_bclk(ext_bclk), .ext_fs(ext_fs),
    .pad_bclk(pad_bclk), .pad_fs(pad_fs), .pad_oe(pad_oe),
    .core_bclk(core_bclk), .core_fs(core_fs)
  );

  assign tx_bclk = pad_bclk[0];
  assign rx_bclk = pad_bclk[1];
  assign tx_fs   = pad_fs[0];
  assign rx_fs   = pad_fs[1];
  assign clk_oe  = pad_oe[0];
  assign fs_oe   = pad_oe[1];

endmodule

// File: tb/test_frame_sync_gen.sv
`timescale 1ns/1ps
module test_frame_sync_gen;

  typedef struct {
    logic [4:0] v;   // {pin bclk, pin fs, oe, core bclk, core fs}
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        ext_bclk = 1'b0;
  logic        ext_fs = 1'b0;
  logic tx_bclk, rx_bclk, tx_fs, rx_fs, clk_oe, fs_oe, core_bclk, core_fs;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   mon_on = 1'b0;
  exp_t q[$];

  frame_sync_gen i_frame_sync_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_bclk(ext_bclk), .ext_fs(ext_fs),
    .tx_bclk(tx_bclk), .rx_bclk(rx_bclk), .tx_fs(tx_fs), .rx_fs(rx_fs),
    .clk_oe(clk_oe), .fs_oe(fs_oe), .core_bclk(core_bclk), .core_fs(core_fs)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: one expected item per input cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && q.size() > 0) begin
        exp_t e;
        logic [4:0] a;
        e = q.pop_front();
        a = {tx_bclk, tx_fs, clk_oe, core_bclk, core_fs};
        chk(a == e.v && rx_bclk == tx_bclk && rx_fs == tx_fs && fs_oe == clk_oe,
            e.req, {rx_bclk, rx_fs, fs_oe, a}, {e.v[4], e.v[3], e.v[2], e.v});
      end
    end
  end

  function automatic logic [15:0] mk_ctrl(input bit en, input bit ms, input bit bi,
                                          input bit fi, input int mode,
                                          input int wl_m1, input int ch_m1);
    return {3'b0, 2'(ch_m1), 5'(wl_m1), 2'(mode), fi, bi, ms, en};
  endfunction

  task automatic push_frames(input int n, input int p, input int w, input bit bi,
                             input bit fi, input int nfr, input string req);
    for (int f = 0; f < nfr; f++)
      for (int b = 0; b <= p; b++)
        for (int c = 0; c < n; c++) begin
          exp_t e;
          logic cb, fb;
          cb = (n == 1) ? 1'b1 : (c < n / 2);
          fb = (b <= w);
          e.v = {cb ^ bi, fb ^ fi, 1'b1, cb, fb};
          e.req = (f == 0 && b == 0 && c == 0) ? "R10 first cycle" : req;
          q.push_back(e);
        end
  endtask

  task automatic push_idle(input bit bi, input bit fi, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      e.v = {bi, fi, 1'b0, 1'b0, 1'b0};
      e.req = "R9/R10 idle after last frame";
      q.push_back(e);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // write captured exactly at posedge number 'edge_n'; called at a negedge
  task automatic wr_at(input int edge_n, input int addr, input logic [15:0] data);
    while (cyc != edge_n - 1) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    mon_on = 1'b0;
  endtask

  // one master run: nfr frames, disable written in the middle of the last one
  task automatic run_case(input int div, input int per, input int wid, input int mode,
                          input int wl_m1, input int ch_m1, input bit bi, input bit fi,
                          input int nfr, input string req);
    int n, p, w, len, k;
    n = (div <= 1) ? 1 : div + 1;
    if (mode == 1)      begin p = 2 * (wl_m1 + 1) - 1; w = wl_m1; end
    else if (mode == 2) begin p = (wl_m1 + 1) * (ch_m1 + 1) - 1; w = 0; end
    else                begin p = per; w = wid; end
    len = n * (p + 1);
    push_frames(n, p, w, bi, fi, nfr, req);
    push_idle(bi, fi, 3);
    wr(1, 16'(div));
    wr(2, 16'(per));
    wr(3, 16'(wid));
    wr(0, mk_ctrl(0, 1, bi, fi, mode, wl_m1, ch_m1));
    chk(clk_oe == 1'b0 && fs_oe == 1'b0, "R9 staged writes start nothing",
        {clk_oe, fs_oe}, 0);
    wr(0, mk_ctrl(1, 1, bi, fi, mode, wl_m1, ch_m1));
    k = cyc;
    mon_on = 1'b1;
    wr_at(k + 1 + (nfr - 1) * len + len / 2, 0, mk_ctrl(0, 1, bi, fi, mode, wl_m1, ch_m1));
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(clk_oe == 0 && fs_oe == 0, "R1 drive enables after reset", {clk_oe, fs_oe}, 0);
    chk({tx_bclk, rx_bclk, tx_fs, rx_fs} == 4'b0, "R1 pins after reset",
        {tx_bclk, rx_bclk, tx_fs, rx_fs}, 0);
    chk({core_bclk, core_fs} == 2'b0, "R1 core outputs after reset", {core_bclk, core_fs}, 0);

    // custom framing, even divide ratio 4
    run_case(3, 4, 1, 0, 0, 0, 0, 0, 2, "R2/R4/R7 custom div4");
    // pass-through divider 0, width above period
    run_case(0, 3, 5, 0, 0, 0, 0, 0, 2, "R3/R4 bypass, full-frame sync");
    // pass-through divider 1, word-pair preset, bit clock inverted
    run_case(1, 0, 0, 1, 3, 0, 1, 0, 2, "R3/R5/R11 bypass word-pair");
    // odd ratio 3, word-pair preset W=2
    run_case(2, 0, 0, 1, 1, 0, 0, 0, 2, "R2/R5 div3 word-pair");
    // packed preset W=3 C=2, ratio 5, both polarities inverted
    run_case(4, 0, 0, 2, 2, 1, 1, 1, 2, "R6/R11 packed inverted");

    // R9: rewrite period, width and divider in the middle of frame 2
    push_frames(3, 3, 1, 0, 0, 2, "R9 old settings hold");
    push_frames(4, 2, 0, 0, 0, 1, "R9 new settings at boundary");
    push_idle(0, 0, 3);
    wr(1, 16'd2);
    wr(2, 16'd3);
    wr(3, 16'd1);
    wr(0, mk_ctrl(1, 1, 0, 0, 0, 0, 0));
    k = cyc;
    mon_on = 1'b1;
    wr_at(k + 17, 2, 16'd2);
    wr_at(k + 18, 3, 16'd0);
    wr_at(k + 19, 1, 16'd3);
    wr_at(k + 31, 0, mk_ctrl(0, 1, 0, 0, 0, 0, 0));
    drain();

    // R8 slave pass-through with bit clock polarity inverted
    wr(0, mk_ctrl(1, 0, 1, 0, 0, 0, 0));
    ext_bclk = 1'b1; ext_fs = 1'b0;
    @(posedge clk); #1;
    chk(clk_oe == 0 && fs_oe == 0, "R8 slave leaves pins undriven", {clk_oe, fs_oe}, 0);
    chk(core_bclk == 0 && core_fs == 0, "R8 slave core follows inputs",
        {core_bclk, core_fs}, 0);
    chk(tx_bclk == 1 && rx_bclk == 1 && tx_fs == 0, "R10/R11 slave pin rest levels",
        {tx_bclk, rx_bclk, tx_fs}, 3'b110);
    @(negedge clk);
    ext_bclk = 1'b0; ext_fs = 1'b1;
    @(posedge clk); #1;
    chk(core_bclk == 1 && core_fs == 1, "R8 slave core follows second pattern",
        {core_bclk, core_fs}, 2'b11);
    chk(clk_oe == 0 && fs_oe == 0, "R8 slave still undriven", {clk_oe, fs_oe}, 0);
    wr(0, mk_ctrl(0, 0, 0, 0, 0, 0, 0));
    @(posedge clk); #1;
    chk(core_bclk == 0 && core_fs == 0, "R10 disabled core outputs low",
        {core_bclk, core_fs}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule